// File: doc/BRIEF.md
# Asynchronous Character Receiver with Break Detection

This block turns a serial, start/stop framed data line into characters for a receive queue. It runs on a receive clock that is 1, 16, 32 or 64 times the bit rate. In the oversampled modes it confirms each start edge halfway into the start bit and then samples every later bit at its centre. In 1x mode the receive clock is assumed to be aligned to the bits already, so each bit is taken on a single edge. Each finished character goes out with a one-cycle write strobe, together with its parity and framing flags.

A line held low for a whole character shows up as a null character with a missing stop bit. The block reports this as a break status and writes nothing while the break lasts. When the first high level returns, it writes exactly one null character with no framing error. An active-low carrier-detect input is synchronised and reported as a status bit. When auto-enable is set, that carrier also gates the receiver: a dropped carrier ends hunting and discards any character in progress.

Top module: `serial_char_rx`

## Requirements
- R1: `clkFactor` selects the receive clock factor: 0 = 1x, 1 = 16x, 2 = 32x, 3 = 64x. In the oversampled modes, let E0 be the clock edge that first sees the line low. The start bit is re-checked at edge E0 + N/2, and data bit i is sampled at edge E0 + N/2 + N·(i+1). Parity and stop follow at the same spacing.
- R2: In 1x mode there is no start re-check. Data bit i is sampled at edge E0 + 1 + i, then parity (if enabled), then stop, one per edge.
- R3: If the line is high at the start re-check, the receiver goes back to hunting and writes no character.
- R4: `charLen` selects 5, 6, 7 or 8 data bits (code + 5). Bits arrive least significant first. `rxData` carries the character right-aligned, with unused upper bits zero.
- R5: With `parityEn` = 1, one parity bit follows the data. `parityOdd` = 0 selects even parity and 1 selects odd parity. `parityErr` is 1 when the received ones count (data plus parity bit) does not match the chosen sense. With `parityEn` = 0 it is 0.
- R6: `framingErr` is 1 for a written character whose stop bit was sampled low.
- R7: A character whose data bits are all zero and whose stop bit is low sets `breakActive`. No write is made for it.
- R8: `breakActive` clears on the first edge that samples the line high. On the following cycle exactly one null character is written, with `framingErr` = 0 and `parityErr` = `parityEn` AND `parityOdd`.
- R9: With `autoEnable` = 1, the receiver is held idle while the synchronised `carrierN` is high. A character in progress when this happens is discarded. With `autoEnable` = 0, `carrierN` has no effect on reception.
- R10: `carrierStatus` equals the inverse of `carrierN` after two flip-flops: a change before edge k appears after edge k+1.
- R11: `rxWrite` is a single-cycle pulse per character, one cycle after the stop-bit sample. `rxData`, `parityErr` and `framingErr` are valid in the same cycle. After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock (N times bit rate) |
| rst_n | input | 1 | Active-low synchronous reset |
| rxLine | input | 1 | Serial data line, idle high |
| carrierN | input | 1 | Carrier detect, active low, asynchronous |
| clkFactor | input | 2 | Clock factor code (R1) |
| charLen | input | 2 | Data bits minus 5 |
| parityEn | input | 1 | Parity bit present |
| parityOdd | input | 1 | 1 = odd parity, 0 = even |
| autoEnable | input | 1 | Carrier gates the receiver |
| rxData | output | 8 | Received character |
| rxWrite | output | 1 | Write strobe toward the receive queue |
| parityErr | output | 1 | Parity error for this character |
| framingErr | output | 1 | Stop bit sampled low |
| breakActive | output | 1 | Break condition in progress |
| carrierStatus | output | 1 | Synchronised carrier present |

## Verification
The bench aims at the edges of break handling. It checks that no write appears while the line stays low, which would catch a design that queues the null-plus-framing character. It checks that exactly one null follows the break's end, with a clear framing flag and a parity flag that depends on odd parity; a faulty design would write two characters or carry the framing error over. A short low glitch is sent in oversampled mode: a receiver that skipped the half-bit re-check would assemble a bogus character from it. The bench also drops the carrier in the middle of a character under auto-enable, where a faulty design would finish and write the partial character. Random frames mix every factor, length and parity mode, with corrupted parity and stop bits, so misplaced sample points and wrong parity sense both show up.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

  typedef enum logic [2:0] {
    ST_HUNT,
    ST_START,
    ST_DATA,
    ST_PARITY,
    ST_STOP,
    ST_BREAK
  } rxState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic clearChar;
    logic takeData;
    logic takeParity;
    logic pushChar;
    logic pushNull;
  } rxStrobe_t;

  localparam logic [1:0] FACTOR_X1 = 2'd0;
  localparam int MIN_DATA_BITS = 5;

endpackage

// File: rtl/serial_rx_ctrl.sv
module serial_rx_ctrl
  import serial_rx_pkg::*;
#(
  parameter int MAX_FACTOR_LOG2 = 6,
  parameter int DATA_W = 8,
  localparam int CNT_W = MAX_FACTOR_LOG2,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rxLine,
  input  logic             carrierN,
  input  logic [1:0]       clkFactor,
  input  logic [1:0]       charLen,
  input  logic             parityEn,
  input  logic             autoEnable,
  input  logic             charZero,
  output rxStrobe_t        strobe,
  output logic [IDX_W-1:0] bitIdx,
  output logic             breakActive,
  output logic             carrierStatus
);

  rxState_e         state, nState;
  logic [CNT_W-1:0] cnt, nCnt;
  logic [CNT_W-1:0] periodM1, halfM1;
  logic [IDX_W-1:0] nIdx, lastBit;
  logic             nBreak;
  logic             carrierMeta, carrierSync;
  logic             rxEnable, sampleNow;

  // two-stage carrier synchroniser, resets to "no carrier"
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      carrierMeta <= 1'b1;
      carrierSync <= 1'b1;
    end else begin
      carrierMeta <= carrierN;
      carrierSync <= carrierMeta;
    end
  end

  assign carrierStatus = ~carrierSync;
  assign rxEnable      = !autoEnable || !carrierSync;

  // bit period and half period in receive clock cycles, minus one
  always_comb begin
    if (clkFactor == FACTOR_X1) begin
      periodM1 = '0;
      halfM1   = '0;
    end else begin
      periodM1 = CNT_W'((32'd1 << (32'(clkFactor) + 32'd3)) - 32'd1);
      halfM1   = CNT_W'((32'd1 << (32'(clkFactor) + 32'd2)) - 32'd1);
    end
  end

  assign lastBit   = IDX_W'(charLen) + IDX_W'(MIN_DATA_BITS - 1);
  assign sampleNow = (cnt == periodM1);

  always_comb begin
    nState = state;
    nCnt   = cnt + 1'b1;
    nIdx   = bitIdx;
    nBreak = breakActive;
    strobe = '0;
    if (!rxEnable) begin
      nState = ST_HUNT;
      nCnt   = '0;
      nBreak = 1'b0;
    end else begin
      unique case (state)
        ST_HUNT: begin
          nCnt = '0;
          if (!rxLine) begin
            strobe.clearChar = 1'b1;
            nIdx   = '0;
            nState = (clkFactor == FACTOR_X1) ? ST_DATA : ST_START;
          end
        end
        ST_START: begin
          if (cnt == halfM1) begin
            nCnt   = '0;
            nState = rxLine ? ST_HUNT : ST_DATA;
          end
        end
        ST_DATA: begin
          if (sampleNow) begin
            nCnt            = '0;
            strobe.takeData = 1'b1;
            if (bitIdx == lastBit) nState = parityEn ? ST_PARITY : ST_STOP;
            else                   nIdx   = bitIdx + 1'b1;
          end
        end
        ST_PARITY: begin
          if (sampleNow) begin
            nCnt              = '0;
            strobe.takeParity = 1'b1;
            nState            = ST_STOP;
          end
        end
        ST_STOP: begin
          if (sampleNow) begin
            nCnt = '0;
            if (!rxLine && charZero) begin
              nBreak = 1'b1;
              nState = ST_BREAK;
            end else begin
              strobe.pushChar = 1'b1;
              nState          = ST_HUNT;
            end
          end
        end
        ST_BREAK: begin
          nCnt = '0;
          if (rxLine) begin
            nBreak          = 1'b0;
            strobe.pushNull = 1'b1;
            nState          = ST_HUNT;
          end
        end
        default: nState = ST_HUNT;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= ST_HUNT;
      cnt         <= '0;
      bitIdx      <= '0;
      breakActive <= 1'b0;
    end else begin
      state       <= nState;
      cnt         <= nCnt;
      bitIdx      <= nIdx;
      breakActive <= nBreak;
    end
  end

endmodule

// File: rtl/serial_rx_datapath.sv
module serial_rx_datapath
  import serial_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rxLine,
  input  rxStrobe_t         strobe,
  input  logic [IDX_W-1:0]  bitIdx,
  input  logic              parityEn,
  input  logic              parityOdd,
  output logic              charZero,
  output logic [DATA_W-1:0] rxData,
  output logic              rxWrite,
  output logic              parityErr,
  output logic              framingErr
);

  logic [DATA_W-1:0] charReg;
  logic              parityAcc;

  // assembly register and running parity
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      charReg   <= '0;
      parityAcc <= 1'b0;
    end else if (strobe.clearChar) begin
      charReg   <= '0;
      parityAcc <= 1'b0;
    end else if (strobe.takeData) begin
      charReg[bitIdx] <= rxLine;
      parityAcc       <= parityAcc ^ rxLine;
    end else if (strobe.takeParity) begin
      parityAcc <= parityAcc ^ rxLine;
    end
  end

  assign charZero = (charReg == '0);

  // output register toward the receive queue
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rxData     <= '0;
      rxWrite    <= 1'b0;
      parityErr  <= 1'b0;
      framingErr <= 1'b0;
    end else begin
      rxWrite <= 1'b0;
      if (strobe.pushChar) begin
        rxData     <= charReg;
        rxWrite    <= 1'b1;
        framingErr <= ~rxLine;
        parityErr  <= parityEn & (parityAcc ^ parityOdd);
      end else if (strobe.pushNull) begin
        rxData     <= '0;
        rxWrite    <= 1'b1;
        framingErr <= 1'b0;
        parityErr  <= parityEn & parityOdd;
      end
    end
  end

endmodule

// File: rtl/serial_char_rx.sv
module serial_char_rx
  import serial_rx_pkg::*;
#(
  parameter int MAX_FACTOR_LOG2 = 6,
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rxLine,
  input  logic              carrierN,
  input  logic [1:0]        clkFactor,
  input  logic [1:0]        charLen,
  input  logic              parityEn,
  input  logic              parityOdd,
  input  logic              autoEnable,
  output logic [DATA_W-1:0] rxData,
  output logic              rxWrite,
  output logic              parityErr,
  output logic              framingErr,
  output logic              breakActive,
  output logic              carrierStatus
);

  rxStrobe_t        strobe;
  logic [IDX_W-1:0] bitIdx;
  logic             charZero;

  serial_rx_ctrl #(
    .MAX_FACTOR_LOG2(MAX_FACTOR_LOG2),
    .DATA_W(DATA_W)
  ) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .rxLine       (rxLine),
    .carrierN     (carrierN),
    .clkFactor    (clkFactor),
    .charLen      (charLen),
    .parityEn     (parityEn),
    .autoEnable   (autoEnable),
    .charZero     (charZero),
    .strobe       (strobe),
    .bitIdx       (bitIdx),
    .breakActive  (breakActive),
    .carrierStatus(carrierStatus)
  );

  serial_rx_datapath #(
    .DATA_W(DATA_W)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .rxLine    (rxLine),
    .strobe    (strobe),
    .bitIdx    (bitIdx),
    .parityEn  (parityEn),
    .parityOdd (parityOdd),
    .charZero  (charZero),
    .rxData    (rxData),
    .rxWrite   (rxWrite),
    .parityErr (parityErr),
    .framingErr(framingErr)
  );

endmodule

// File: rtl/serial_rx_checker.sv
module serial_rx_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rxLine,
  input logic              carrierN,
  input logic              parityEn,
  input logic              parityOdd,
  input logic              autoEnable,
  input logic [DATA_W-1:0] rxData,
  input logic              rxWrite,
  input logic              parityErr,
  input logic              framingErr,
  input logic              breakActive,
  input logic              carrierStatus
);

  logic [2:0] sinceReset;

  always_ff @(posedge clk) begin
    if (!rst_n)                 sinceReset <= '0;
    else if (sinceReset != 3'd7) sinceReset <= sinceReset + 1'b1;
  end

  // R11: write strobe lasts one cycle
  p_write_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rxWrite |=> !rxWrite);

  // R7: entering break produces no write
  p_break_no_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(breakActive) |-> !rxWrite);

  // R8: line high during break ends it with one clean null character
  p_break_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (breakActive && rxLine && (!autoEnable || carrierStatus)) |=>
      (!breakActive && rxWrite && rxData == '0 && !framingErr &&
       parityErr == ($past(parityEn) && $past(parityOdd))));

  // R10: carrier status trails the pin by two flops
  p_carrier_sync_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sinceReset >= 3'd3) |-> (carrierStatus == !$past(carrierN, 2)));

  // R9: no write while auto-enable holds the receiver off
  p_auto_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sinceReset >= 3'd5 && $past(autoEnable) && $past(carrierN, 3) &&
     $past(carrierN, 4)) |-> !rxWrite);

endmodule

bind serial_char_rx serial_rx_checker #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/serial_char_rx_tb.sv
`timescale 1ns/1ps
module serial_char_rx_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rxLine = 1'b1;
  logic       carrierN = 1'b1;
  logic [1:0] clkFactor = 2'd0;
  logic [1:0] charLen = 2'd3;
  logic       parityEn = 1'b0;
  logic       parityOdd = 1'b0;
  logic       autoEnable = 1'b0;
  logic [7:0] rxData;
  logic       rxWrite, parityErr, framingErr, breakActive, carrierStatus;

  int checks = 0;
  int fails = 0;
  logic [9:0] wrQ[$];

  always #10 clk = ~clk;

  serial_char_rx u_dut (
    .clk(clk), .rst_n(rst_n), .rxLine(rxLine), .carrierN(carrierN),
    .clkFactor(clkFactor), .charLen(charLen), .parityEn(parityEn),
    .parityOdd(parityOdd), .autoEnable(autoEnable), .rxData(rxData),
    .rxWrite(rxWrite), .parityErr(parityErr), .framingErr(framingErr),
    .breakActive(breakActive), .carrierStatus(carrierStatus)
  );

  always @(negedge clk) if (rst_n && rxWrite) wrQ.push_back({rxData, parityErr, framingErr});

  function automatic int factorOf(input logic [1:0] f);
    return (f == 2'd0) ? 1 : (1 << (int'(f) + 3));
  endfunction

  function automatic logic [7:0] maskOf(input logic [1:0] len);
    return 8'hFF >> (3 - int'(len));
  endfunction

  function automatic logic parityBitOf(input logic [7:0] d);
    return (^(d & maskOf(charLen))) ^ parityOdd;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic holdBit(input logic v);
    rxLine = v;
    repeat (factorOf(clkFactor)) @(negedge clk);
  endtask

  task automatic idleBits(input int n);
    rxLine = 1'b1;
    repeat (n * factorOf(clkFactor)) @(negedge clk);
  endtask

  task automatic sendFrame(input logic [7:0] d, input bit corruptPar, input logic stopVal);
    holdBit(1'b0);
    for (int i = 0; i < int'(charLen) + 5; i++) holdBit(d[i]);
    if (parityEn) holdBit(parityBitOf(d) ^ corruptPar);
    holdBit(stopVal);
    idleBits(3);
  endtask

  task automatic expectOne(input logic [7:0] d, input bit pe, input bit fe, input string req);
    check(wrQ.size() == 1, req, "write count", wrQ.size(), 1);
    if (wrQ.size() >= 1)
      check(wrQ[0] == {d, pe, fe}, req, "char/pe/fe", int'(wrQ[0]), int'({d, pe, fe}));
    wrQ.delete();
  endtask

  task automatic runChar(input logic [7:0] d, input bit corruptPar, input logic stopVal,
                         input string req);
    wrQ.delete();
    sendFrame(d, corruptPar, stopVal);
    expectOne(d & maskOf(charLen), parityEn & corruptPar, !stopVal, req);
  endtask

  task automatic runBreak(input string req);
    wrQ.delete();
    holdBit(1'b0);
    for (int i = 0; i < int'(charLen) + 5; i++) holdBit(1'b0);
    if (parityEn) holdBit(1'b0);
    holdBit(1'b0);
    repeat (3 * factorOf(clkFactor)) @(negedge clk);
    check(breakActive == 1'b1, "R7", "break set", breakActive, 1);
    check(wrQ.size() == 0, "R7", "no write during break", wrQ.size(), 0);
    rxLine = 1'b1;
    repeat (2) @(negedge clk);
    check(breakActive == 1'b0, "R8", "break cleared", breakActive, 0);
    idleBits(3);
    expectOne(8'h00, parityEn & parityOdd, 1'b0, req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R11 watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h00C0FFEE));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    check(rxWrite == 0 && rxData == 0 && breakActive == 0 && framingErr == 0 && parityErr == 0,
          "R11", "reset outputs", {rxWrite, breakActive, framingErr, parityErr}, 0);
    check(carrierStatus == 0, "R10", "reset carrier", carrierStatus, 0);

    // R2, R4: 1x, 8 bits
    clkFactor = 2'd0; charLen = 2'd3; parityEn = 0;
    idleBits(4);
    runChar(8'hA5, 0, 1'b1, "R2");
    // R1, R5: 16x, 5 bits, even parity
    clkFactor = 2'd1; charLen = 2'd0; parityEn = 1; parityOdd = 0;
    idleBits(2);
    runChar(8'hF3, 0, 1'b1, "R1");
    // R5: 32x, 7 bits, odd parity, corrupted
    clkFactor = 2'd2; charLen = 2'd2; parityOdd = 1;
    runChar(8'h5A, 1, 1'b1, "R5");
    // R6: 64x, 6 bits, stop low
    clkFactor = 2'd3; charLen = 2'd1; parityEn = 0;
    runChar(8'h2C, 0, 1'b0, "R6");

    // R3: glitch shorter than half a bit in 16x
    clkFactor = 2'd1; charLen = 2'd3;
    wrQ.delete();
    rxLine = 1'b0;
    repeat (4) @(negedge clk);
    idleBits(14);
    check(wrQ.size() == 0, "R3", "false start writes", wrQ.size(), 0);
    runChar(8'h81, 0, 1'b1, "R3");

    // R7, R8: breaks in 16x with odd parity, and 1x without parity
    parityEn = 1; parityOdd = 1;
    runBreak("R8");
    clkFactor = 2'd0; parityEn = 0;
    idleBits(4);
    runBreak("R8");

    // R10: carrier synchroniser latency
    carrierN = 1'b0;
    @(negedge clk);
    check(carrierStatus == 0, "R10", "after one edge", carrierStatus, 0);
    @(negedge clk);
    check(carrierStatus == 1, "R10", "after two edges", carrierStatus, 1);

    // R9: carrier ignored when auto-enable is off
    carrierN = 1'b1;
    idleBits(4);
    runChar(8'h3C, 0, 1'b1, "R9");
    // R9: carrier absent blocks reception
    clkFactor = 2'd1; autoEnable = 1'b1;
    idleBits(1);
    wrQ.delete();
    sendFrame(8'h77, 0, 1'b1);
    check(wrQ.size() == 0, "R9", "no carrier writes", wrQ.size(), 0);
    carrierN = 1'b0;
    idleBits(1);
    runChar(8'h77, 0, 1'b1, "R9");
    // R9: carrier lost mid-character
    wrQ.delete();
    holdBit(1'b0);
    holdBit(1'b1); holdBit(1'b0); holdBit(1'b1);
    carrierN = 1'b1;
    for (int i = 3; i < 8; i++) holdBit(1'b1);
    holdBit(1'b1);
    idleBits(3);
    check(wrQ.size() == 0, "R9", "discarded partial", wrQ.size(), 0);
    carrierN = 1'b0;
    idleBits(1);
    runChar(8'h42, 0, 1'b1, "R9");
    autoEnable = 1'b0;

    // random frames across all modes
    for (int n = 0; n < 40; n++) begin
      logic [7:0] d;
      bit corrupt;
      logic stopVal;
      clkFactor = 2'($urandom_range(0, 3));
      charLen   = 2'($urandom_range(0, 3));
      parityEn  = 1'($urandom_range(0, 1));
      parityOdd = 1'($urandom_range(0, 1));
      d         = 8'($urandom);
      corrupt   = ($urandom_range(0, 3) == 0);
      stopVal   = 1'b1;
      if (((d & maskOf(charLen)) != 0) && ($urandom_range(0, 3) == 0)) stopVal = 1'b0;
      idleBits(1);
      runChar(d, corrupt, stopVal, "R4");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule